// File: doc/BRIEF.md
# Coprocessor Gate and Floating-Point Control Registers

This block keeps three small control registers for a processor core: a coprocessor enable mask with one bit per coprocessor, a floating-point control register and a floating-point status register. A few spare user-register slots sit beside them as plain 32-bit storage. Every write goes through a fixed per-register mask. The rounding field of the control register is brought out as a one-hot vector, so the arithmetic units need no decode of their own.

The decode stage presents each coprocessor instruction on an issue strobe, together with the number of the coprocessor it targets. The block answers in the same cycle. If the enable bit for that coprocessor is set, the instruction may proceed. If the bit is clear, the block raises an exception pulse with a cause code of a fixed base plus the coprocessor number, and withholds permission. A write to the enable mask raises a one-cycle resynchronisation request, so that the front end can discard anything it decoded under the old mask. When the coprocessor option is left out by parameter, every instruction is allowed.

Top module: `cpx_ctrl`

## Requirements
- R1: After reset every register reads zero, all enable bits are clear, the rounding output shows nearest-even, and no exception or resync is signalled.
- R2: A write to select 0 (enable mask) stores only the low 8 data bits; bit n enables coprocessor n and is visible on cp_enable_o from the next cycle.
- R3: A write to select 1 (FP control) stores the data ANDed with 0xFFFFF07F.
- R4: A write to select 2 (FP status) stores the data ANDed with 0xFFFFFF80.
- R5: A write to any select from 3 to 7 stores all 32 data bits unchanged, and every select reads back its stored value.
- R6: round_mode_o is one-hot and follows control bits 1:0: value 0 sets bit 0 (nearest-even), 1 sets bit 1 (toward zero), 2 sets bit 2 (toward plus infinity), 3 sets bit 3 (toward minus infinity).
- R7: An issue aimed at coprocessor n with enable bit n set raises issue_ok_o in the same cycle, and no exception.
- R8: An issue aimed at coprocessor n with enable bit n clear raises exc_o in the same cycle with exc_cause_o = 32 + n, holds issue_ok_o low, and changes no register.
- R9: Without an issue, exc_o and issue_ok_o are low and exc_cause_o is zero.
- R10: resync_o is high for exactly the one cycle after a write to the enable mask, and stays low after writes to other selects.
- R11: An issue in the same cycle as an enable write is judged by the old mask. The new mask governs from the next cycle.
- R12: With the coprocessor option off (COPRO_EN = 0), every issue is allowed and no exception is ever raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select for the write |
| wr_data_i | input | 32 | Write data, masked per register |
| rd_sel_i | input | 3 | Register select for the read |
| rd_data_o | output | 32 | Stored value of the selected register |
| cp_enable_o | output | 8 | Current enable mask, one bit per coprocessor |
| round_mode_o | output | 4 | One-hot rounding mode |
| resync_o | output | 1 | Pulse one cycle after an enable write |
| issue_i | input | 1 | A coprocessor instruction issues this cycle |
| issue_cp_i | input | 3 | Coprocessor the instruction targets |
| issue_ok_o | output | 1 | Instruction may proceed |
| exc_o | output | 1 | Coprocessor-disabled exception pulse |
| exc_cause_o | output | 6 | Cause code, base plus coprocessor number |

## Verification
An enable write and an issue check can fall in the same cycle. The check reads the mask register while the write is still on its way into it. The bench provokes this by writing a mask that sets a coprocessor's bit while issuing to that same coprocessor. It expects the exception with the old cause code in that cycle, then a clean pass on the next issue together with the resync pulse. It also clears a bit in the same cycle as an issue, which must still pass once under the old mask.

// File: rtl/cpx_ctrl_pkg.sv
package cpx_ctrl_pkg;

  localparam int unsigned DATA_W    = 32;
  localparam int unsigned SEL_CPEN  = 0;
  localparam int unsigned SEL_FCTL  = 1;
  localparam int unsigned SEL_FSTAT = 2;

  localparam logic [DATA_W-1:0] MASK_FCTL  = 32'hFFFF_F07F;
  localparam logic [DATA_W-1:0] MASK_FSTAT = 32'hFFFF_FF80;

  typedef enum logic [1:0] {
    RND_NEAR = 2'd0,
    RND_ZERO = 2'd1,
    RND_POS  = 2'd2,
    RND_NEG  = 2'd3
  } rnd_e;

  // one-hot positions on the rounding output
  localparam int unsigned RND_OH_W = 4;

endpackage

// File: rtl/cpx_regfile.sv
module cpx_regfile
  import cpx_ctrl_pkg::*;
#(
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned NUM_CP = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [SEL_W-1:0]  rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [NUM_CP-1:0] cpen_o,
  output logic [1:0]        rnd_o,
  output logic              cpen_wr_o
);

  localparam int unsigned NREG = 2 ** SEL_W;
  localparam logic [DATA_W-1:0] MASK_CPEN = DATA_W'((64'd1 << NUM_CP) - 64'd1);

  logic [DATA_W-1:0] mask  [NREG];
  logic [DATA_W-1:0] reg_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_mask
    if (g == SEL_CPEN) begin : g_cpen
      assign mask[g] = MASK_CPEN;
    end else if (g == SEL_FCTL) begin : g_fctl
      assign mask[g] = MASK_FCTL;
    end else if (g == SEL_FSTAT) begin : g_fstat
      assign mask[g] = MASK_FSTAT;
    end else begin : g_plain
      assign mask[g] = '1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) reg_q[i] <= '0;
    end else if (wr_en_i) begin
      for (int i = 0; i < NREG; i++) begin
        if (wr_sel_i == SEL_W'(i)) reg_q[i] <= wr_data_i & mask[i];
      end
    end
  end

  assign rd_data_o = reg_q[rd_sel_i];
  assign cpen_o    = reg_q[SEL_CPEN][NUM_CP-1:0];
  assign rnd_o     = reg_q[SEL_FCTL][1:0];
  assign cpen_wr_o = wr_en_i && (wr_sel_i == SEL_W'(SEL_CPEN));

endmodule

// File: rtl/cpx_round_dec.sv
module cpx_round_dec
  import cpx_ctrl_pkg::*;
(
  input  logic [1:0]          rnd_i,
  output logic [RND_OH_W-1:0] oh_o
);

  rnd_e mode;
  assign mode = rnd_e'(rnd_i);

  always_comb begin
    oh_o = '0;
    unique case (mode)
      RND_NEAR: oh_o[0] = 1'b1;
      RND_ZERO: oh_o[1] = 1'b1;
      RND_POS:  oh_o[2] = 1'b1;
      RND_NEG:  oh_o[3] = 1'b1;
      default:  oh_o    = '0;
    endcase
  end

endmodule

// File: rtl/cpx_gate.sv
module cpx_gate #(
  parameter int unsigned NUM_CP   = 8,
  parameter int unsigned CP_W     = 3,
  parameter int unsigned CAUSE_W  = 6,
  parameter int unsigned EXC_BASE = 32,
  parameter bit          COPRO_EN = 1'b1
) (
  input  logic [NUM_CP-1:0]  cpen_i,
  input  logic               issue_i,
  input  logic [CP_W-1:0]    issue_cp_i,
  output logic               ok_o,
  output logic               exc_o,
  output logic [CAUSE_W-1:0] cause_o
);

  logic bit_set;

  if (COPRO_EN) begin : g_check
    assign bit_set = cpen_i[issue_cp_i];
  end else begin : g_open
    assign bit_set = 1'b1;
  end

  assign ok_o    = issue_i && bit_set;
  assign exc_o   = issue_i && !bit_set;
  assign cause_o = exc_o ? (CAUSE_W'(EXC_BASE) + CAUSE_W'(issue_cp_i)) : '0;

endmodule

// File: rtl/cpx_ctrl.sv
module cpx_ctrl
  import cpx_ctrl_pkg::*;
#(
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned NUM_CP   = 8,
  parameter int unsigned CP_W     = $clog2(NUM_CP),
  parameter int unsigned CAUSE_W  = 6,
  parameter int unsigned EXC_BASE = 32,
  parameter bit          COPRO_EN = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [SEL_W-1:0]    wr_sel_i,
  input  logic [31:0]         wr_data_i,
  input  logic [SEL_W-1:0]    rd_sel_i,
  output logic [31:0]         rd_data_o,
  output logic [NUM_CP-1:0]   cp_enable_o,
  output logic [3:0]          round_mode_o,
  output logic                resync_o,
  input  logic                issue_i,
  input  logic [CP_W-1:0]     issue_cp_i,
  output logic                issue_ok_o,
  output logic                exc_o,
  output logic [CAUSE_W-1:0]  exc_cause_o
);

  logic [1:0] rnd;
  logic       cpen_wr;
  logic       resync_q;

  cpx_regfile #(
    .SEL_W  (SEL_W),
    .NUM_CP (NUM_CP)
  ) i_regfile (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .rd_sel_i  (rd_sel_i),
    .rd_data_o (rd_data_o),
    .cpen_o    (cp_enable_o),
    .rnd_o     (rnd),
    .cpen_wr_o (cpen_wr)
  );

  cpx_round_dec i_round_dec (
    .rnd_i (rnd),
    .oh_o  (round_mode_o)
  );

  cpx_gate #(
    .NUM_CP   (NUM_CP),
    .CP_W     (CP_W),
    .CAUSE_W  (CAUSE_W),
    .EXC_BASE (EXC_BASE),
    .COPRO_EN (COPRO_EN)
  ) i_gate (
    .cpen_i     (cp_enable_o),
    .issue_i    (issue_i),
    .issue_cp_i (issue_cp_i),
    .ok_o       (issue_ok_o),
    .exc_o      (exc_o),
    .cause_o    (exc_cause_o)
  );

  // front end flushes decode when the mask changes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) resync_q <= 1'b0;
    else         resync_q <= cpen_wr;
  end

  assign resync_o = resync_q;

endmodule

// File: rtl/cpx_ctrl_chk.sv
module cpx_ctrl_chk #(
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned NUM_CP   = 8,
  parameter int unsigned CP_W     = 3,
  parameter int unsigned CAUSE_W  = 6,
  parameter int unsigned EXC_BASE = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [SEL_W-1:0]   wr_sel_i,
  input logic [NUM_CP-1:0]  cp_enable_o,
  input logic [3:0]         round_mode_o,
  input logic               resync_o,
  input logic               issue_i,
  input logic [CP_W-1:0]    issue_cp_i,
  input logic               issue_ok_o,
  input logic               exc_o,
  input logic [CAUSE_W-1:0] exc_cause_o
);

  logic cpen_wr;
  assign cpen_wr = wr_en_i && (wr_sel_i == '0);

  // R2
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cpen_wr) |-> $stable(cp_enable_o));

  // R6
  round_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(round_mode_o) == 1);

  // R7
  issue_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |-> (issue_ok_o != exc_o));

  // R8
  exc_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> (exc_cause_o == CAUSE_W'(EXC_BASE) + CAUSE_W'(issue_cp_i)) && !issue_ok_o);

  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_i |-> !exc_o && !issue_ok_o && (exc_cause_o == '0));

  // R10
  resync_after_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpen_wr |=> resync_o);

  // R10
  resync_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpen_wr |=> !resync_o);

endmodule

bind cpx_ctrl cpx_ctrl_chk #(
  .SEL_W    (SEL_W),
  .NUM_CP   (NUM_CP),
  .CP_W     (CP_W),
  .CAUSE_W  (CAUSE_W),
  .EXC_BASE (EXC_BASE)
) i_cpx_ctrl_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_sel_i     (wr_sel_i),
  .cp_enable_o  (cp_enable_o),
  .round_mode_o (round_mode_o),
  .resync_o     (resync_o),
  .issue_i      (issue_i),
  .issue_cp_i   (issue_cp_i),
  .issue_ok_o   (issue_ok_o),
  .exc_o        (exc_o),
  .exc_cause_o  (exc_cause_o)
);

// File: tb/test_cpx_ctrl.sv
`timescale 1ns/1ps
module test_cpx_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_sel = '0;
  logic        issue = 1'b0;
  logic [2:0]  issue_cp = '0;

  logic [31:0] rd_data;
  logic [7:0]  cp_en;
  logic [3:0]  rnd_oh;
  logic        resync, ok, exc;
  logic [5:0]  cause;

  logic [31:0] rd_data_n;
  logic [7:0]  cp_en_n;
  logic [3:0]  rnd_oh_n;
  logic        resync_n, ok_n, exc_n;
  logic [5:0]  cause_n;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cpx_ctrl i_cpx_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .cp_enable_o(cp_en), .round_mode_o(rnd_oh), .resync_o(resync),
    .issue_i(issue), .issue_cp_i(issue_cp), .issue_ok_o(ok),
    .exc_o(exc), .exc_cause_o(cause)
  );

  cpx_ctrl #(.COPRO_EN(1'b0)) i_cpx_ctrl_open (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data_n),
    .cp_enable_o(cp_en_n), .round_mode_o(rnd_oh_n), .resync_o(resync_n),
    .issue_i(issue), .issue_cp_i(issue_cp), .issue_ok_o(ok_n),
    .exc_o(exc_n), .exc_cause_o(cause_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // write, returns at the negedge after the capturing edge
  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] sel, input logic [31:0] exp);
    rd_sel = sel;
    #0.5;
    chk(tag, rd_data, exp);
  endtask

  task automatic t_reset;
    for (int s = 0; s < 8; s++) rd_chk("R1 read", 3'(s), 32'h0);
    chk("R1 enable", 32'(cp_en), 32'h0);
    chk("R1 round", 32'(rnd_oh), 32'h1);
    chk("R1 resync", 32'(resync), 32'h0);
    chk("R1 exc", 32'(exc), 32'h0);
  endtask

  task automatic t_enable_mask;
    wr(3'd0, 32'hDEAD_BEEF);
    chk("R10 resync after enable write", 32'(resync), 32'h1);
    chk("R2 enable out", 32'(cp_en), 32'hEF);
    rd_chk("R2 read", 3'd0, 32'h0000_00EF);
    @(negedge clk);
    chk("R10 resync single cycle", 32'(resync), 32'h0);
  endtask

  task automatic t_fctl;
    wr(3'd1, 32'hFFFF_FFFF);
    chk("R10 no resync on ctl write", 32'(resync), 32'h0);
    rd_chk("R3 ctl all ones", 3'd1, 32'hFFFF_F07F);
    chk("R6 mode 3", 32'(rnd_oh), 32'h8);
    wr(3'd1, 32'h1234_5601);
    rd_chk("R3 ctl pattern", 3'd1, 32'h1234_5001);
    chk("R6 mode 1", 32'(rnd_oh), 32'h2);
    wr(3'd1, 32'h0000_0002);
    chk("R6 mode 2", 32'(rnd_oh), 32'h4);
    wr(3'd1, 32'h0000_0F80);
    chk("R6 mode 0", 32'(rnd_oh), 32'h1);
    rd_chk("R3 ctl hole", 3'd1, 32'h0000_0000);
  endtask

  task automatic t_fstat;
    wr(3'd2, 32'hFFFF_FFFF);
    rd_chk("R4 status all ones", 3'd2, 32'hFFFF_FF80);
    wr(3'd2, 32'h1234_567F);
    rd_chk("R4 status pattern", 3'd2, 32'h1234_5600);
    chk("R10 no resync on status write", 32'(resync), 32'h0);
  endtask

  task automatic t_plain;
    for (int s = 3; s < 8; s++) wr(3'(s), 32'hA5C3_0000 + 32'(s));
    for (int s = 3; s < 8; s++) rd_chk("R5 plain slot", 3'(s), 32'hA5C3_0000 + 32'(s));
  endtask

  task automatic t_issue;
    logic [7:0] m;
    m = 8'h05;
    wr(3'd0, 32'(m));
    for (int n = 0; n < 8; n++) begin
      @(negedge clk);
      issue = 1'b1; issue_cp = 3'(n);
      #0.5;
      if (m[n]) begin
        chk("R7 ok", 32'(ok), 32'h1);
        chk("R7 no exc", 32'(exc), 32'h0);
      end else begin
        chk("R8 exc", 32'(exc), 32'h1);
        chk("R8 cause", 32'(cause), 32'd32 + 32'(n));
        chk("R8 blocked", 32'(ok), 32'h0);
      end
      chk("R12 open ok", 32'(ok_n), 32'h1);
      chk("R12 open no exc", 32'(exc_n), 32'h0);
    end
    @(negedge clk);
    issue = 1'b0;
    #0.5;
    chk("R9 idle exc", 32'(exc), 32'h0);
    chk("R9 idle ok", 32'(ok), 32'h0);
    chk("R9 idle cause", 32'(cause), 32'h0);
    chk("R8 mask unchanged", 32'(cp_en), 32'h05);
    rd_chk("R8 status unchanged", 3'd2, 32'h1234_5600);
    rd_chk("R8 slot unchanged", 3'd7, 32'hA5C3_0007);
  endtask

  task automatic t_same_cycle;
    // mask 0x05 in place; enable cp3 while issuing to it
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'd0; wr_data = 32'h0000_000D;
    issue = 1'b1; issue_cp = 3'd3;
    #0.5;
    chk("R11 old mask exc", 32'(exc), 32'h1);
    chk("R11 old mask cause", 32'(cause), 32'd35);
    @(negedge clk);
    wr_en = 1'b0;
    #0.5;
    chk("R11 new mask ok", 32'(ok), 32'h1);
    chk("R10 resync with new mask", 32'(resync), 32'h1);
    // clear cp0 while issuing to it: passes once under the old mask
    @(negedge clk);
    wr_en = 1'b1; wr_data = 32'h0000_000C; issue_cp = 3'd0;
    #0.5;
    chk("R11 old mask ok", 32'(ok), 32'h1);
    @(negedge clk);
    wr_en = 1'b0;
    #0.5;
    chk("R11 new mask exc cause", 32'(cause), 32'd32);
    @(negedge clk);
    issue = 1'b0;
  endtask

  initial begin
    #12.5;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable_mask();
    t_fctl();
    t_fstat();
    t_plain();
    t_issue();
    t_same_cycle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule